// File: doc/BRIEF.md
# T1 Transmit Channel Byte Processor

This block sits in the transmit path of a 24-channel T1 framer, ahead of the serializer. For every outgoing channel byte it receives the channel number, the frame index within the superframe, the framing mode, a yellow-alarm request and that channel's four signaling bits. It returns the byte that goes to the line.

Per-channel configuration lives in seven 8-bit registers that are loaded through a small synchronous write port. Three of them form a 24-bit clear-channel mask and three form a 24-bit idle mask. The seventh holds the idle code.

Each byte passes through four steps in a fixed order:
1. Idle-code substitution.
2. Robbed-bit signaling in the signaling frames.
3. Zero-code stuffing of bit 7.
4. The D4 yellow-alarm overwrite of bit 2.

Bits are numbered 1 (MSB, sent first, `[7]`) to 8 (LSB, `[0]`). A clear channel skips signaling and stuffing. It does not skip the yellow-alarm overwrite. Two global force bits, when both are set, bring stuffing back onto every channel.

Top module: `t1_tx_chan_proc`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by one clock, and `out_byte` carries the processed byte of that earlier cycle. When `in_valid` is 0, `out_byte` keeps its last value. After reset, `out_valid` and `out_byte` are 0.
- R2: A write with `cfg_wr`=1 loads `cfg_wdata` into a register chosen by `cfg_addr`:
  - Offsets 0..2 are the clear mask, where channel index k (0..23) is offset k/8, bit k%8.
  - Offsets 3..5 are the idle mask, with the same bit layout.
  - Offset 6 is the idle code.
  - Offsets 7..15 are ignored.
  - A write takes effect for bytes presented on the next clock.
- R3: Reset clears both masks and sets the idle code to 0x7F.
- R4: A channel whose idle bit is 1 has its input byte replaced by the idle code. Bit `[7]` of the register becomes line bit 1.
- R5: Signaling on a non-clear channel replaces `[0]` in two frames for D4 (`esf_mode`=0) and in four frames for ESF (`esf_mode`=1). `in_frame` is zero-based and `sig_abcd` is {A,B,C,D}, with A at `[3]`.
  - In both modes: `in_frame` 5 takes A and `in_frame` 11 takes B.
  - In ESF only: `in_frame` 17 takes C and `in_frame` 23 takes D.
- R6: When stuffing is enabled for a channel and the byte after the signaling step is 0x00, that byte becomes 0x02 (`[1]` set). Stuffing is enabled on a non-clear channel, and on every channel when `force_stuff_a` and `force_stuff_b` are both 1.
- R7: Stuffing on a clear channel needs both force bits. Either force bit alone changes nothing.
- R8: With `esf_mode`=0 and `yellow_req`=1, `out_byte[6]` is 0 on every channel, including clear ones. This is applied last, so it can clear a bit that blocked stuffing. In ESF, `yellow_req` has no effect.
- R9: A clear channel gets no signaling and no stuffing. Its idle substitution still applies, and the idle code goes out unchanged.
- R10: An `in_chan` value of 24 or more is treated as a channel with both mask bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register offset |
| cfg_wdata | input | 8 | Register write data |
| in_valid | input | 1 | Input byte strobe |
| in_byte | input | 8 | Payload byte, [7] = bit 1 |
| in_chan | input | 5 | Channel index 0..23 |
| in_frame | input | 5 | Frame index in superframe, 0..23 |
| esf_mode | input | 1 | 1 = ESF, 0 = D4 |
| yellow_req | input | 1 | Yellow alarm being sent |
| sig_abcd | input | 4 | Signaling bits {A,B,C,D} |
| force_stuff_a | input | 1 | Global stuffing force bit A |
| force_stuff_b | input | 1 | Global stuffing force bit B |
| out_valid | output | 1 | Output byte strobe |
| out_byte | output | 8 | Processed byte |

## Verification
The bench targets the orderings between the four steps:
- **Signaling that zeroes a byte.** The byte must then be stuffed. A design that stuffs before signaling would send 0x00.
- **A 0x40 byte under a D4 yellow alarm.** The output must be 0x00, because the overwrite comes last. A design that overwrites first would send 0x02.
- **Idle code of 0x00.** A non-clear channel must send 0x02 and a clear channel must send 0x00.

It also covers:
- **Force bits.** It drives them one at a time and together. A design that ORs them would stuff clear channels with only one bit set.
- **Out-of-range inputs.** It sends channel indices past 23 and writes to unused offsets. A design that aliases these would corrupt real mask bits.
- **Frame 17 in D4.** A design that ignores the mode would rob a bit there.

// File: rtl/t1_tx_chan_proc.sv
module t1_tx_chan_proc #(
  parameter int NCH = 24,
  parameter int FRAMES = 24,
  parameter logic [7:0] IDLE_RST = 8'h7F
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [3:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  input  logic [4:0] in_chan,
  input  logic [4:0] in_frame,
  input  logic       esf_mode,
  input  logic       yellow_req,
  input  logic [3:0] sig_abcd,
  input  logic       force_stuff_a,
  input  logic       force_stuff_b,
  output logic       out_valid,
  output logic [7:0] out_byte
);
  localparam int NGRP = NCH / 8;
  localparam int OFF_IDLE = NGRP;
  localparam int OFF_CODE = 2 * NGRP;
  localparam logic [4:0] FR_A = 5'(FRAMES / 4 - 1);
  localparam logic [4:0] FR_B = 5'(FRAMES / 2 - 1);
  localparam logic [4:0] FR_C = 5'(3 * FRAMES / 4 - 1);
  localparam logic [4:0] FR_D = 5'(FRAMES - 1);

  logic [NCH-1:0] clr_mask, idl_mask;
  logic [7:0] idle_code;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clr_mask  <= '0;
      idl_mask  <= '0;
      idle_code <= IDLE_RST;
    end else if (cfg_wr) begin
      for (int g = 0; g < NGRP; g++) begin
        if (int'(cfg_addr) == g)            clr_mask[8*g +: 8] <= cfg_wdata;
        if (int'(cfg_addr) == OFF_IDLE + g) idl_mask[8*g +: 8] <= cfg_wdata;
      end
      if (int'(cfg_addr) == OFF_CODE) idle_code <= cfg_wdata;
    end
  end

  logic chan_ok, is_clr, is_idl;
  assign chan_ok = int'(in_chan) < NCH;
  assign is_clr  = chan_ok && clr_mask[in_chan];
  assign is_idl  = chan_ok && idl_mask[in_chan];

  logic sig_hit, sig_bit;
  always_comb begin
    sig_hit = 1'b1;
    sig_bit = 1'b0;
    if (in_frame == FR_A)                 sig_bit = sig_abcd[3];
    else if (in_frame == FR_B)            sig_bit = sig_abcd[2];
    else if (esf_mode && in_frame == FR_C) sig_bit = sig_abcd[1];
    else if (esf_mode && in_frame == FR_D) sig_bit = sig_abcd[0];
    else                                  sig_hit = 1'b0;
  end

  logic [7:0] s_idle, s_sig, s_stuff, s_yel;
  logic stuff_en;
  assign s_idle   = is_idl ? idle_code : in_byte;
  assign s_sig    = (sig_hit && !is_clr) ? {s_idle[7:1], sig_bit} : s_idle;
  assign stuff_en = !is_clr || (force_stuff_a && force_stuff_b);
  assign s_stuff  = (stuff_en && s_sig == 8'h00) ? 8'h02 : s_sig;
  assign s_yel    = (!esf_mode && yellow_req) ? (s_stuff & 8'hBF) : s_stuff;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_byte  <= 8'h00;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_byte <= s_yel;
    end
  end
endmodule

module t1_tx_chan_proc_chk #(parameter int NCH = 24) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [4:0]     in_chan,
  input logic [4:0]     in_frame,
  input logic           esf_mode,
  input logic           yellow_req,
  input logic [3:0]     sig_abcd,
  input logic           force_stuff_a,
  input logic           force_stuff_b,
  input logic [NCH-1:0] clr_mask,
  input logic           out_valid,
  input logic [7:0]     out_byte
);
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && out_valid) |=> $stable(out_byte));
  a_r8_yellow_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !esf_mode && yellow_req) |=> !out_byte[6]);
  a_r6_forced_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && force_stuff_a && force_stuff_b && !(yellow_req && !esf_mode))
      |=> out_byte != 8'h00);
  a_r5_sig_a: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && int'(in_chan) < NCH && !clr_mask[in_chan] && in_frame == 5'd5)
      |=> out_byte[0] == $past(sig_abcd[3]));
endmodule

bind t1_tx_chan_proc t1_tx_chan_proc_chk #(.NCH(NCH)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
  .in_frame(in_frame), .esf_mode(esf_mode), .yellow_req(yellow_req),
  .sig_abcd(sig_abcd), .force_stuff_a(force_stuff_a),
  .force_stuff_b(force_stuff_b), .clr_mask(clr_mask),
  .out_valid(out_valid), .out_byte(out_byte));

// File: tb/t1_tx_chan_proc_tb.sv
module t1_tx_chan_proc_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  logic cfg_wr = 0;
  logic [3:0] cfg_addr = 0;
  logic [7:0] cfg_wdata = 0;
  logic in_valid = 0;
  logic [7:0] in_byte = 0;
  logic [4:0] in_chan = 0, in_frame = 0;
  logic esf_mode = 0, yellow_req = 0, force_stuff_a = 0, force_stuff_b = 0;
  logic [3:0] sig_abcd = 0;
  logic out_valid;
  logic [7:0] out_byte;

  always #2.5 clk = ~clk;

  t1_tx_chan_proc dut_i (.*);

  int total = 0, bad = 0;
  bit m_clr[24], m_idl[24];
  logic [7:0] m_code = 8'h7F;
  logic [7:0] last_out = 0;

  function automatic logic [7:0] model(logic [7:0] b, int ch, int fr);
    bit clr = 0, idl = 0;
    logic [7:0] v;
    int slot = -1;
    if (ch < 24) begin clr = m_clr[ch]; idl = m_idl[ch]; end
    v = idl ? m_code : b;
    if (fr == 5) slot = 0;
    else if (fr == 11) slot = 1;
    else if (esf_mode && fr == 17) slot = 2;
    else if (esf_mode && fr == 23) slot = 3;
    if (!clr && slot >= 0) v[0] = sig_abcd[3 - slot];
    if ((!clr || (force_stuff_a && force_stuff_b)) && v == 8'h00) v = 8'h02;
    if (!esf_mode && yellow_req) v[6] = 1'b0;
    return v;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    in_valid = 0; cfg_wr = 1; cfg_addr = 4'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0;
    for (int j = 0; j < 8; j++) begin
      if (a < 3) m_clr[8*a + j] = d[j];
      else if (a < 6) m_idl[8*(a-3) + j] = d[j];
    end
    if (a == 6) m_code = d;
  endtask

  task automatic send(logic [7:0] b, int ch, int fr, string tag);
    logic [7:0] exp;
    @(negedge clk);
    in_valid = 1; in_byte = b; in_chan = 5'(ch); in_frame = 5'(fr);
    exp = model(b, ch, fr);
    @(negedge clk);
    check({tag, " valid"}, {7'd0, out_valid}, 8'h01);
    check(tag, out_byte, exp);
    last_out = exp;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", {7'd0, out_valid}, 8'h00);
    check("R1 reset byte", out_byte, 8'h00);
    rst_n = 1;
    send(8'h00, 2, 0, "R3 mask clear");
    wr(3, 8'h04);
    send(8'hAA, 2, 0, "R3 idle code");
    send(8'hAA, 2, 0, "R4");
    wr(6, 8'h00);
    send(8'h55, 2, 0, "R6 idle zero");
    sig_abcd = 4'b1010;
    send(8'hFE, 5, 5, "R5 A");
    send(8'h01, 5, 11, "R5 B then R6");
    send(8'h10, 5, 17, "R5 d4 no C");
    esf_mode = 1;
    send(8'h10, 5, 17, "R5 C");
    send(8'h11, 5, 23, "R5 D");
    wr(0, 8'h20);
    send(8'h10, 5, 17, "R9 no sig");
    send(8'h00, 5, 0, "R9 no stuff");
    force_stuff_a = 1;
    send(8'h00, 5, 0, "R7 a only");
    force_stuff_a = 0; force_stuff_b = 1;
    send(8'h00, 5, 0, "R7 b only");
    force_stuff_a = 1;
    send(8'h00, 5, 0, "R6 forced");
    send(8'h10, 5, 17, "R6 forced no sig");
    force_stuff_a = 0; force_stuff_b = 0;
    wr(3, 8'h20);
    send(8'h99, 5, 0, "R9 idle clear");
    wr(3, 8'h00); wr(6, 8'h7F);
    esf_mode = 0; yellow_req = 1;
    send(8'hFF, 7, 0, "R8 normal");
    send(8'hFF, 5, 0, "R8 clear");
    send(8'h40, 7, 0, "R8 last");
    esf_mode = 1;
    send(8'hFF, 7, 0, "R8 esf");
    yellow_req = 0;
    wr(2, 8'h80);
    send(8'h00, 23, 0, "R2 top bit");
    wr(5, 8'hFF);
    send(8'h55, 24, 0, "R10 24");
    send(8'h00, 25, 0, "R10 25");
    send(8'h00, 16, 0, "R2 idle grp");
    wr(7, 8'hFF); wr(15, 8'hFF);
    send(8'h00, 0, 0, "R2 unused");
    @(negedge clk);
    in_valid = 0; in_byte = 8'h33;
    @(negedge clk);
    check("R1 drop valid", {7'd0, out_valid}, 8'h00);
    check("R1 hold", out_byte, last_out);
    for (int i = 0; i < 3000; i++) begin
      if (i % 97 == 0) wr($urandom % 8, 8'($urandom));
      esf_mode = 1'($urandom); yellow_req = ($urandom % 5 == 0);
      force_stuff_a = 1'($urandom); force_stuff_b = 1'($urandom);
      sig_abcd = 4'($urandom);
      send(($urandom % 3 == 0) ? 8'h00 : (($urandom % 4 == 0) ? 8'h40 : 8'($urandom)),
           $urandom % 26, $urandom % 24, "rand");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule